// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block turns a fast system clock into the bit timing of an I2C controller. A control field holds two cascaded divider values: a 2-bit prescale value A and a 6-bit value B. Together they define a time unit of (A+1)×(B+1) system clocks. Twenty-two of these units make one SCL period. The period is split into a fixed high part of 10 units followed by a low part of 12 units. The block emits a one-cycle strobe when SCL should fall and another when it should rise, and it also drives the resulting SCL level. The bus engine gates the counting with a run input, and a stretch input freezes the counters while a target holds the clock low.

Beside the tick generator sits a search helper that picks a divider pair for a requested bus rate. Given the system clock frequency and the wanted SCL frequency in hertz, it first computes floor and ceiling of fin/(22×fscl) with a bit-serial divider. It then tries every value of A and keeps the pair with the smallest total divide that is at least that ceiling. Because the divide never falls below the ceiling, the resulting rate never exceeds the request. Requests above 400 kHz are refused, as are requests whose divide cannot be reached.

Top module: `scl_divider`

## Requirements
- R1: With the run input high and stretch low, successive fall strobes are exactly 22×(A+1)×(B+1) clock cycles apart.
- R2: A fall strobe comes 10 units after each rise strobe, or after the period start, and a rise strobe comes 12 units after each fall strobe. A unit is (A+1)×(B+1) cycles. `scl_level` is 0 from the cycle of a fall strobe and 1 from the cycle of a rise strobe. The two strobes are never high together.
- R3: A pulse on `cfg_wr` loads A from `cfg_field[7:6]` and B from `cfg_field[5:0]`. It also clears both counters and restarts the period with SCL high. The first fall strobe then comes 10×(A+1)×(B+1) cycles after the load edge.
- R4: While `run` is low, the counters, the phase and `scl_level` hold their values and no strobe is produced. Counting resumes where it stopped, so the pending strobe is delayed by exactly the number of idle cycles.
- R5: While `stretch` is high, the block freezes in the same way, with no strobe and a delay equal to the stretch length.
- R6: After reset, `scl_level` is 1, both strobes are 0, `calc_done` and `calc_err` are 0, and both divider fields are 0.
- R7: A search whose requested rate is 0 or above 400000 Hz ends with `calc_err` = 1 and both divider outputs 0.
- R8: A search for which floor(fin/(22×fscl)) is 0 or greater than 256 ends with `calc_err` = 1 and both divider outputs 0.
- R9: Otherwise, let K = ceil(fin/(22×fscl)). For each A from 0 to 3, the candidate is B+1 = ceil(K/(A+1)), and it is valid only if B+1 ≤ 64. The search returns the valid candidate with the smallest (A+1)×(B+1). On a tie it returns the lowest A.
- R10: If no value of A yields a valid candidate, the search ends with `calc_err` = 1 and both divider outputs 0.
- R11: `calc_done` is a single-cycle pulse that rises FREQ_W+1 cycles after the clock edge that samples `calc_start`. `calc_err`, `calc_div_a` and `calc_div_b` keep their values after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the divider fields and restart the period |
| cfg_field | input | 8 | Divider field: A in bits 7:6, B in bits 5:0 |
| run | input | 1 | Engine busy; counting allowed |
| stretch | input | 1 | Target holds SCL low; freeze counting |
| fall_tick | output | 1 | One-cycle strobe at the end of the high phase |
| rise_tick | output | 1 | One-cycle strobe at the end of the low phase |
| scl_level | output | 1 | SCL level implied by the current phase |
| calc_start | input | 1 | Start a divider-pair search |
| calc_fin_hz | input | 32 | System clock frequency in Hz |
| calc_fscl_hz | input | 32 | Requested SCL frequency in Hz |
| calc_done | output | 1 | Search finished (one cycle) |
| calc_err | output | 1 | Request refused or unreachable |
| calc_div_a | output | 2 | Chosen value of A |
| calc_div_b | output | 6 | Chosen value of B |

## Verification
The hardest situation to reach is a freeze that covers the exact cycle in which a strobe would otherwise have fired. A freeze elsewhere in the period only lengthens it and hides whether the strobe was dropped or just postponed. The bench counts cycles from a field load. It lowers `run`, and in a second pass raises `stretch`, a few cycles before the computed fall point, and holds it well past that point. It then requires silence during the freeze and a strobe exactly the freeze length later. For the search, the unreachable case K = 257 needs a rate whose floor quotient is exactly 256 with a nonzero remainder. The bench builds it directly as 256×22×fscl + 1 together with its exact neighbour.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    // SCL period in divider units and its split
    localparam int PERIOD_UNITS  = 22;
    localparam int HIGH_UNITS    = 10;
    // Highest bus rate the search accepts
    localparam int FAST_LIMIT_HZ = 400000;

    typedef enum logic [1:0] {
        SRCH_IDLE,
        SRCH_DIVIDE,
        SRCH_PICK
    } srch_state_e;
endpackage

// File: rtl/scl_unit_counter.sv
// Cascaded prescale (A) and main (B) counters; unit is high on the
// cycle both reach their limits while advancing.
module scl_unit_counter #(
    parameter int A_W = 2,
    parameter int B_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           adv,
    input  logic [A_W-1:0] a_lim,
    input  logic [B_W-1:0] b_lim,
    output logic           unit
);
    typedef struct packed {
        logic [A_W-1:0] ca;
        logic [B_W-1:0] cb;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unit  = 1'b0;
        if (load) begin
            cnt_d = '0;
        end else if (adv) begin
            if (cnt_q.ca == a_lim) begin
                cnt_d.ca = '0;
                if (cnt_q.cb == b_lim) begin
                    cnt_d.cb = '0;
                    unit     = 1'b1;
                end else begin
                    cnt_d.cb = cnt_q.cb + B_W'(1);
                end
            end else begin
                cnt_d.ca = cnt_q.ca + A_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scl_phase_gen.sv
// Counts units through one SCL period and emits the edge strobes.
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic unit,
    output logic fall_tick,
    output logic rise_tick,
    output logic scl_level
);
    localparam int PH_W = $clog2(PERIOD_UNITS);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            scl;
        logic            fall;
        logic            rise;
    } ph_t;

    ph_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        if (load) begin
            st_d.phase = '0;
            st_d.scl   = 1'b1;
        end else if (unit) begin
            if (st_q.phase == PH_W'(HIGH_UNITS - 1)) begin
                st_d.fall = 1'b1;
                st_d.scl  = 1'b0;
            end
            if (st_q.phase == PH_W'(PERIOD_UNITS - 1)) begin
                st_d.rise  = 1'b1;
                st_d.scl   = 1'b1;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: '0, scl: 1'b1, fall: 1'b0, rise: 1'b0};
        else        st_q <= st_d;
    end

    assign fall_tick = st_q.fall;
    assign rise_tick = st_q.rise;
    assign scl_level = st_q.scl;
endmodule

// File: rtl/scl_pair_search.sv
// Bit-serial division of fin by 22*fscl, then a parallel pick over A.
module scl_pair_search
    import scl_div_pkg::*;
#(
    parameter int A_W    = 2,
    parameter int B_W    = 6,
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] fin_hz,
    input  logic [FREQ_W-1:0] fscl_hz,
    output logic              done,
    output logic              err,
    output logic [A_W-1:0]    div_a,
    output logic [B_W-1:0]    div_b
);
    localparam int DW   = FREQ_W + 5;
    localparam int CW   = $clog2(FREQ_W);
    localparam int KW   = A_W + B_W + 1;
    localparam int PW   = KW + A_W + 1;
    localparam int NA   = 2 ** A_W;
    localparam int MAXP = 2 ** (A_W + B_W);

    typedef struct packed {
        srch_state_e       st;
        logic [CW-1:0]     cnt;
        logic [FREQ_W-1:0] num;
        logic [DW-1:0]     den;
        logic [DW-1:0]     rem;
        logic [FREQ_W-1:0] quo;
        logic              too_fast;
        logic              done;
        logic              err;
        logic [A_W-1:0]    a;
        logic [B_W-1:0]    b;
    } srch_t;

    srch_t s_d, s_q;

    logic [DW:0]       trial;
    logic [FREQ_W-1:0] k_full;
    logic [KW-1:0]     kk;
    logic              out_range;
    logic [KW-1:0]     bp1  [NA];
    logic [PW-1:0]     prod [NA];
    logic [NA-1:0]     ok;
    logic              found;
    logic [PW-1:0]     bestp;

    assign trial     = {s_q.rem, s_q.num[FREQ_W-1]};
    assign k_full    = s_q.quo + FREQ_W'(s_q.rem != '0);
    assign kk        = KW'(k_full);
    assign out_range = (s_q.quo == '0) || (s_q.quo > FREQ_W'(MAXP));

    for (genvar i = 0; i < NA; i++) begin : g_cand
        localparam int DIVV = i + 1;
        assign bp1[i]  = (kk + KW'(i)) / KW'(DIVV);
        assign prod[i] = PW'(bp1[i]) * PW'(DIVV);
        assign ok[i]   = (bp1[i] <= KW'(2 ** B_W));
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        found    = 1'b0;
        bestp    = '0;
        case (s_q.st)
            SRCH_IDLE: begin
                if (start) begin
                    s_d.st       = SRCH_DIVIDE;
                    s_d.cnt      = '0;
                    s_d.num      = fin_hz;
                    s_d.den      = DW'(fscl_hz) * DW'(22);
                    s_d.rem      = '0;
                    s_d.quo      = '0;
                    s_d.too_fast = (fscl_hz == '0) || (fscl_hz > FREQ_W'(FAST_LIMIT_HZ));
                end
            end
            SRCH_DIVIDE: begin
                if (trial >= {1'b0, s_q.den}) begin
                    s_d.rem = DW'(trial - {1'b0, s_q.den});
                    s_d.quo = {s_q.quo[FREQ_W-2:0], 1'b1};
                end else begin
                    s_d.rem = DW'(trial);
                    s_d.quo = {s_q.quo[FREQ_W-2:0], 1'b0};
                end
                s_d.num = {s_q.num[FREQ_W-2:0], 1'b0};
                s_d.cnt = s_q.cnt + CW'(1);
                if (s_q.cnt == CW'(FREQ_W - 1)) s_d.st = SRCH_PICK;
            end
            SRCH_PICK: begin
                s_d.done = 1'b1;
                s_d.st   = SRCH_IDLE;
                s_d.a    = '0;
                s_d.b    = '0;
                for (int i = 0; i < NA; i++) begin
                    if (ok[i] && (!found || prod[i] < bestp)) begin
                        found = 1'b1;
                        bestp = prod[i];
                        s_d.a = A_W'(i);
                        s_d.b = B_W'(bp1[i] - KW'(1));
                    end
                end
                s_d.err = s_q.too_fast || out_range || !found;
                if (s_d.err) begin
                    s_d.a = '0;
                    s_d.b = '0;
                end
            end
            default: s_d.st = SRCH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SRCH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign done  = s_q.done;
    assign err   = s_q.err;
    assign div_a = s_q.a;
    assign div_b = s_q.b;
endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
    parameter int A_W    = 2,
    parameter int B_W    = 6,
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [A_W+B_W-1:0] cfg_field,
    input  logic              run,
    input  logic              stretch,
    output logic              fall_tick,
    output logic              rise_tick,
    output logic              scl_level,
    input  logic              calc_start,
    input  logic [FREQ_W-1:0] calc_fin_hz,
    input  logic [FREQ_W-1:0] calc_fscl_hz,
    output logic              calc_done,
    output logic              calc_err,
    output logic [A_W-1:0]    calc_div_a,
    output logic [B_W-1:0]    calc_div_b
);
    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } field_t;

    field_t fld_d, fld_q;
    logic   adv;
    logic   unit;

    always_comb begin
        fld_d = fld_q;
        if (cfg_wr) begin
            fld_d.a = cfg_field[A_W+B_W-1:B_W];
            fld_d.b = cfg_field[B_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    assign adv = run && !stretch && !cfg_wr;

    scl_unit_counter #(.A_W(A_W), .B_W(B_W)) u_unit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_wr),
        .adv   (adv),
        .a_lim (fld_q.a),
        .b_lim (fld_q.b),
        .unit  (unit)
    );

    scl_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_wr),
        .unit      (unit),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .scl_level (scl_level)
    );

    scl_pair_search #(.A_W(A_W), .B_W(B_W), .FREQ_W(FREQ_W)) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (calc_start),
        .fin_hz  (calc_fin_hz),
        .fscl_hz (calc_fscl_hz),
        .done    (calc_done),
        .err     (calc_err),
        .div_a   (calc_div_a),
        .div_b   (calc_div_b)
    );
endmodule

// File: rtl/scl_divider_chk.sv
module scl_divider_chk
    import scl_div_pkg::*;
#(
    parameter int A_W    = 2,
    parameter int B_W    = 6,
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              run,
    input logic              stretch,
    input logic              fall_tick,
    input logic              rise_tick,
    input logic              scl_level,
    input logic              calc_start,
    input logic [FREQ_W-1:0] calc_fscl_hz,
    input logic              calc_done,
    input logic              calc_err
);
    logic busy;
    logic fast;
    int   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            fast <= 1'b0;
            cnt  <= 0;
        end else if ((calc_done || !busy) && calc_start) begin
            busy <= 1'b1;
            cnt  <= 0;
            fast <= (calc_fscl_hz == '0) || (calc_fscl_hz > FREQ_W'(FAST_LIMIT_HZ));
        end else if (calc_done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1;
        end
    end

    a_r2_no_double_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_tick && rise_tick));

    a_r2_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |-> !scl_level);

    a_r2_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> scl_level);

    a_r2_scl_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_level) |-> (fall_tick || rise_tick || $past(cfg_wr)));

    // R4 and R5: a frozen cycle produces no strobe
    a_r5_frozen_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stretch || !run) |-> (!fall_tick && !rise_tick));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |=> !calc_done);

    a_r11_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> (busy && cnt == FREQ_W + 1));

    a_r7_fast_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_done && fast) |-> calc_err);
endmodule

bind scl_divider scl_divider_chk #(.A_W(A_W), .B_W(B_W), .FREQ_W(FREQ_W)) u_scl_divider_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .run          (run),
    .stretch      (stretch),
    .fall_tick    (fall_tick),
    .rise_tick    (rise_tick),
    .scl_level    (scl_level),
    .calc_start   (calc_start),
    .calc_fscl_hz (calc_fscl_hz),
    .calc_done    (calc_done),
    .calc_err     (calc_err)
);

// File: tb/test_scl_divider.sv
module test_scl_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_field = '0;
    logic        run = 1'b0;
    logic        stretch = 1'b0;
    logic        fall_tick, rise_tick, scl_level;
    logic        calc_start = 1'b0;
    logic [31:0] calc_fin_hz = '0;
    logic [31:0] calc_fscl_hz = '0;
    logic        calc_done, calc_err;
    logic [1:0]  calc_div_a;
    logic [5:0]  calc_div_b;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    scl_divider i_scl_divider (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_field(cfg_field),
        .run(run), .stretch(stretch), .fall_tick(fall_tick),
        .rise_tick(rise_tick), .scl_level(scl_level),
        .calc_start(calc_start), .calc_fin_hz(calc_fin_hz),
        .calc_fscl_hz(calc_fscl_hz), .calc_done(calc_done),
        .calc_err(calc_err), .calc_div_a(calc_div_a), .calc_div_b(calc_div_b)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int a, input int b);
        @(negedge clk);
        cfg_field = {2'(a), 6'(b)};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // counts negedges until the chosen strobe is seen
    task automatic wait_tick(input bit want_rise, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_rise ? rise_tick : fall_tick) && n < limit);
    endtask

    // hold for len cycles, counting strobes seen meanwhile
    task automatic freeze(input bit use_stretch, input int len, output int seen, output bit moved);
        logic lvl;
        seen = 0;
        moved = 1'b0;
        lvl = scl_level;
        if (use_stretch) stretch = 1'b1; else run = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (fall_tick || rise_tick) seen++;
            if (scl_level !== lvl) moved = 1'b1;
        end
        stretch = 1'b0;
        run = 1'b1;
    endtask

    function automatic void model(input longint fin, input longint f,
                                  output bit err, output int a, output int b);
        longint d, q, r, k, bp, bestp;
        bit found;
        err = 1'b0; a = 0; b = 0; found = 1'b0; bestp = 0;
        if (f == 0 || f > 400000) begin err = 1'b1; return; end
        d = 22 * f;
        q = fin / d;
        r = fin % d;
        if (q == 0 || q > 256) begin err = 1'b1; return; end
        k = q + (r != 0 ? 1 : 0);
        for (int ai = 0; ai < 4; ai++) begin
            bp = (k + ai) / (ai + 1);
            if (bp <= 64 && (!found || bp * (ai + 1) < bestp)) begin
                found = 1'b1;
                bestp = bp * (ai + 1);
                a = ai;
                b = int'(bp) - 1;
            end
        end
        if (!found) begin err = 1'b1; a = 0; b = 0; end
    endfunction

    task automatic run_calc(input longint fin, input longint f, input string req);
        int n;
        bit e_err;
        int e_a, e_b;
        model(fin, f, e_err, e_a, e_b);
        @(negedge clk);
        calc_fin_hz = 32'(fin);
        calc_fscl_hz = 32'(f);
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
        n = 0;
        while (!calc_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == 33, "R11 latency", n, 33);
        check(calc_err == e_err, req, calc_err, e_err);
        check(calc_div_a == 2'(e_a), req, calc_div_a, e_a);
        check(calc_div_b == 6'(e_b), req, calc_div_b, e_b);
        @(negedge clk);
        check(!calc_done, "R11 single pulse", calc_done, 0);
        check(calc_err == e_err && calc_div_a == 2'(e_a) && calc_div_b == 6'(e_b),
              "R11 result held", {calc_err, calc_div_a, calc_div_b}, {e_err, 2'(e_a), 6'(e_b)});
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, seen, m;
        bit moved;
        int bl[5] = '{0, 1, 3, 13, 63};

        // R6: reset state
        #9;
        check(scl_level == 1'b1, "R6 scl", scl_level, 1);
        check(!fall_tick && !rise_tick, "R6 ticks", {fall_tick, rise_tick}, 0);
        check(!calc_done && !calc_err, "R6 search", {calc_done, calc_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6: fields reset to zero, so one unit is one cycle
        @(negedge clk);
        run = 1'b1;
        wait_tick(1'b0, 100, n);
        check(n == 10, "R6 zero fields", n, 10);

        // R1, R2, R3 sweep
        for (int ai = 0; ai < 4; ai++) begin
            for (int bi = 0; bi < 5; bi++) begin
                m = (ai + 1) * (bl[bi] + 1);
                load_cfg(ai, bl[bi]);
                wait_tick(1'b0, 30 * m, n);
                check(n == 10 * m, "R3 first fall", n, 10 * m);
                check(scl_level == 1'b0, "R2 low after fall", scl_level, 0);
                wait_tick(1'b1, 30 * m, n);
                check(n == 12 * m, "R2 low phase", n, 12 * m);
                check(scl_level == 1'b1, "R2 high after rise", scl_level, 1);
                wait_tick(1'b0, 30 * m, n);
                check(n == 10 * m, "R2 high phase", n, 10 * m);
                wait_tick(1'b0, 30 * m, n);
                check(n == 22 * m, "R1 period", n, 22 * m);
            end
        end

        // R4: idle across the fall point (unit 6, fall at 60)
        load_cfg(1, 2);
        for (int i = 0; i < 55; i++) @(negedge clk);
        freeze(1'b0, 37, seen, moved);
        check(seen == 0, "R4 no strobe while idle", seen, 0);
        check(!moved, "R4 level held", moved, 0);
        wait_tick(1'b0, 500, n);
        check(55 + 37 + n == 97, "R4 delayed fall", 55 + 37 + n, 97);

        // R5: stretch across the same point
        load_cfg(1, 2);
        for (int i = 0; i < 58; i++) @(negedge clk);
        freeze(1'b1, 21, seen, moved);
        check(seen == 0, "R5 no strobe while stretched", seen, 0);
        check(!moved, "R5 level held", moved, 0);
        wait_tick(1'b0, 500, n);
        check(58 + 21 + n == 81, "R5 delayed fall", 58 + 21 + n, 81);

        // R5: stretch across a rise point (rise at 132)
        load_cfg(1, 2);
        for (int i = 0; i < 130; i++) @(negedge clk);
        freeze(1'b1, 9, seen, moved);
        check(seen == 0 && !moved, "R5 rise held", seen, 0);
        wait_tick(1'b1, 500, n);
        check(130 + 9 + n == 141, "R5 delayed rise", 130 + 9 + n, 141);

        // search: hand-worked pairs
        run_calc(100000000, 100000, "R9 100M/100k");
        check(calc_div_a == 0 && calc_div_b == 45, "R9 expect A0 B45", {calc_div_a, calc_div_b}, 45);
        run_calc(500000000, 100000, "R9 500M/100k");
        check(calc_div_a == 3 && calc_div_b == 56, "R9 expect A3 B56", {calc_div_a, calc_div_b}, {2'd3, 6'd56});
        run_calc(300000000, 100000, "R9 300M/100k");
        check(calc_div_a == 2 && calc_div_b == 45, "R9 expect A2 B45", {calc_div_a, calc_div_b}, {2'd2, 6'd45});
        run_calc(100000000, 400000, "R9 tie lowest A");
        check(calc_div_a == 0 && calc_div_b == 11, "R9 expect A0 B11", {calc_div_a, calc_div_b}, 11);
        run_calc(56320000, 10000, "R9 quotient 256 exact");
        check(calc_div_a == 3 && calc_div_b == 63, "R9 expect A3 B63", {calc_div_a, calc_div_b}, {2'd3, 6'd63});
        run_calc(56320001, 10000, "R10 no candidate");
        check(calc_err == 1'b1, "R10 err", calc_err, 1);
        run_calc(1000000, 100000, "R8 quotient zero");
        check(calc_err == 1'b1, "R8 err low", calc_err, 1);
        run_calc(200000000, 10000, "R8 quotient large");
        check(calc_err == 1'b1, "R8 err high", calc_err, 1);
        run_calc(100000000, 400001, "R7 above limit");
        check(calc_err == 1'b1, "R7 err fast", calc_err, 1);
        run_calc(100000000, 0, "R7 zero rate");
        check(calc_err == 1'b1, "R7 err zero", calc_err, 1);

        // R9 sweep of requested rates
        for (int f = 5000; f <= 400000; f += 7919)
            run_calc(100000000, f, "R9 sweep 100M");
        for (int f = 9000; f <= 400000; f += 12347)
            run_calc(333333333, f, "R9 sweep 333M");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule